// File: doc/BRIEF.md
# DMA Channel Address Generator

This block sequences the addresses of one channel of a slave DMA engine. A start pulse captures a packed configuration word together with separate block length, transaction length, per-side step, wrap pointer and wrap target values. After that, the block presents a source address, a destination address and the read and write beat sizes. These values advance by one beat each time the downstream bus logic accepts a beat through a valid/ready handshake.

Every transfer is split into three nested levels. A fragment, a block and a transaction each have their own byte counter, and the block pulses a one-cycle done flag at each level boundary it crosses. The request mode decides how much work one hardware request releases:
- a single fragment,
- a single block,
- the whole transaction.

Two address shaping features apply to one side at a time. A fixed-address mode holds either the source or the destination constant, as a device register port needs. A wrap feature sends the selected side back to a programmed target address when that side reaches a programmed pointer, which forms a ring buffer.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset the block is idle, with busy, beat_valid and all done flags low. A start pulse in idle (with abort low) loads all configuration and both start addresses, raises busy on the next cycle, and keeps beat_valid low until a request arrives.
- R2: The configuration word is laid out as follows: read width code at bits 31:30, write width code at bits 29:28, request mode at bits 25:24, wrap side select at bit 23, wrap enable at bit 22, fixed side select at bit 21, fixed enable at bit 20, and fragment length in bytes at bits 16:0. Width codes 0, 1, 2 and 3 give beat sizes of 1, 2, 4 and 8 bytes on beat_bytes (read width) and wr_bytes (write width).
- R3: A beat is accepted when beat_valid and beat_ready are both high and abort is low. On each accepted beat, every side that is neither fixed nor wrapping adds its step to its address. A cycle with no accepted beat changes neither address and pulses no done flag.
- R4: With fixed enable set, fixed select 1 holds the destination address constant and fixed select 0 holds the source address constant. The other side keeps stepping.
- R5: With wrap enable set, wrap select 0 applies the wrap to the source side and wrap select 1 applies it to the destination side. If the selected side's current address equals the wrap pointer on an accepted beat, its next address is the wrap target instead of address plus step. A fixed side holds even if it is also selected for wrap.
- R6: Each accepted beat reduces the fragment, block and transaction byte counters by the read beat size. A level ends on a beat when its remaining count is at most the beat size. A block end also ends the fragment, and a transaction end also ends the block. The matching done flags are high for exactly the one cycle after the accepting clock edge, and the ended counters reload.
- R7: In request mode 0 (fragment), the block stops presenting beats after each fragment end that is not the transaction end, and waits for the next request.
- R8: In request mode 1 (block), the block stops presenting beats after each block end that is not the transaction end, and waits for the next request.
- R9: In request modes 2 (transaction) and 3 (list), one request runs the transaction to its end. Busy and beat_valid are low in the same cycle that trsc_done is high.
- R10: A start pulse while busy is ignored. The addresses, steps and state continue with the configuration that was loaded first.
- R11: Abort returns the block to idle on the next cycle, with no done pulse and no address advance. Abort takes precedence over a simultaneous start or beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load configuration and begin a transaction (idle only) |
| abort | input | 1 | Return to idle immediately |
| cfg_word | input | 32 | Packed channel configuration |
| blk_len | input | CNT_W | Block length in bytes |
| trsc_len | input | CNT_W | Transaction length in bytes |
| src_start | input | ADDR_W | Initial source address |
| dst_start | input | ADDR_W | Initial destination address |
| src_step | input | STEP_W | Source increment per beat |
| dst_step | input | STEP_W | Destination increment per beat |
| wrap_ptr | input | ADDR_W | Address that triggers the wrap |
| wrap_to | input | ADDR_W | Address the wrapping side jumps to |
| req | input | 1 | Hardware request releasing the next unit of work |
| beat_ready | input | 1 | Downstream accepts the presented beat |
| busy | output | 1 | A transaction is loaded and not finished |
| beat_valid | output | 1 | A beat is presented |
| src_addr | output | ADDR_W | Current source address |
| dst_addr | output | ADDR_W | Current destination address |
| beat_bytes | output | 4 | Read beat size in bytes |
| wr_bytes | output | 4 | Write beat size in bytes |
| frag_done | output | 1 | One-cycle pulse at a fragment end |
| blk_done | output | 1 | One-cycle pulse at a block end |
| trsc_done | output | 1 | One-cycle pulse at the transaction end |

## Verification
The hardest situation to reach is two level boundaries arriving on the same beat while the downstream handshake is stalling. This happens when a block length is not a multiple of the fragment length, so the fragment counter is cut short and reloaded by the block end rather than by its own count. The stimulus produces it with a 6-byte fragment, 10-byte block and 14-byte transaction at 2-byte beats, and holds beat_ready low on every third cycle. A bench-side byte model predicts every done pulse and checks that the stalled cycles change nothing. Stalls in fragment and block request modes are then reached by running the same model and checking that beats stop until the next request.

// File: rtl/dma_addr_seq_pkg.sv
package dma_addr_seq_pkg;

  localparam int CFG_W     = 32;
  localparam int FRAG_W    = 17;
  localparam int RD_WID_HI = 31;
  localparam int WR_WID_HI = 29;
  localparam int MODE_HI   = 25;
  localparam int WRAP_SEL  = 23;
  localparam int WRAP_EN   = 22;
  localparam int FIX_SEL   = 21;
  localparam int FIX_EN    = 20;
  localparam int NUM_SIDES = 2;
  localparam int NUM_LVLS  = 3;

  typedef enum logic [1:0] {
    RQ_FRAG  = 2'd0,
    RQ_BLOCK = 2'd1,
    RQ_TRSC  = 2'd2,
    RQ_LIST  = 2'd3
  } req_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [1:0]        rd_wid;
    logic [1:0]        wr_wid;
    req_mode_e         mode;
    logic              wrap_sel;
    logic              wrap_en;
    logic              fix_sel;
    logic              fix_en;
    logic [FRAG_W-1:0] frag_len;
  } chan_cfg_t;

  function automatic logic [3:0] wid_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

endpackage

// File: rtl/dma_seq_cfg.sv
module dma_seq_cfg
  import dma_addr_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STEP_W = 16,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CFG_W-1:0]  cfg_word_i,
  input  logic [CNT_W-1:0]  blk_len_i,
  input  logic [CNT_W-1:0]  trsc_len_i,
  input  logic [STEP_W-1:0] src_step_i,
  input  logic [STEP_W-1:0] dst_step_i,
  input  logic [ADDR_W-1:0] wrap_ptr_i,
  input  logic [ADDR_W-1:0] wrap_to_i,
  output chan_cfg_t         cfg_o,
  output logic [CNT_W-1:0]  blk_len_o,
  output logic [CNT_W-1:0]  trsc_len_o,
  output logic [STEP_W-1:0] src_step_o,
  output logic [STEP_W-1:0] dst_step_o,
  output logic [ADDR_W-1:0] wrap_ptr_o,
  output logic [ADDR_W-1:0] wrap_to_o
);

  chan_cfg_t         cfg_d, cfg_q;
  logic [CNT_W-1:0]  blk_q, trsc_q;
  logic [STEP_W-1:0] sstep_q, dstep_q;
  logic [ADDR_W-1:0] wptr_q, wto_q;
  logic              cfg_unused;

  assign cfg_unused = ^{cfg_word_i[27:26], cfg_word_i[19:17]};

  always_comb begin
    cfg_d.rd_wid   = cfg_word_i[RD_WID_HI -: 2];
    cfg_d.wr_wid   = cfg_word_i[WR_WID_HI -: 2];
    cfg_d.mode     = req_mode_e'(cfg_word_i[MODE_HI -: 2]);
    cfg_d.wrap_sel = cfg_word_i[WRAP_SEL];
    cfg_d.wrap_en  = cfg_word_i[WRAP_EN];
    cfg_d.fix_sel  = cfg_word_i[FIX_SEL];
    cfg_d.fix_en   = cfg_word_i[FIX_EN];
    cfg_d.frag_len = cfg_word_i[FRAG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      blk_q   <= '0;
      trsc_q  <= '0;
      sstep_q <= '0;
      dstep_q <= '0;
      wptr_q  <= '0;
      wto_q   <= '0;
    end else if (load_i) begin
      cfg_q   <= cfg_d;
      blk_q   <= blk_len_i;
      trsc_q  <= trsc_len_i;
      sstep_q <= src_step_i;
      dstep_q <= dst_step_i;
      wptr_q  <= wrap_ptr_i;
      wto_q   <= wrap_to_i;
    end
  end

  assign cfg_o      = cfg_q;
  assign blk_len_o  = blk_q;
  assign trsc_len_o = trsc_q;
  assign src_step_o = sstep_q;
  assign dst_step_o = dstep_q;
  assign wrap_ptr_o = wptr_q;
  assign wrap_to_o  = wto_q;

endmodule

// File: rtl/dma_seq_side.sv
module dma_seq_side #(
  parameter int ADDR_W = 32,
  parameter int STEP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] init_i,
  input  logic              adv_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              hold_i,
  input  logic              wrap_i,
  input  logic [ADDR_W-1:0] wrap_ptr_i,
  input  logic [ADDR_W-1:0] wrap_to_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] addr_d, addr_q;
  logic              addr_en;
  logic              at_ptr;

  assign at_ptr  = (addr_q == wrap_ptr_i);
  assign addr_en = load_i | adv_i;

  always_comb begin
    addr_d = addr_q;
    if (load_i) begin
      addr_d = init_i;
    end else if (adv_i && !hold_i) begin
      if (wrap_i && at_ptr) begin
        addr_d = wrap_to_i;
      end else begin
        addr_d = addr_q + ADDR_W'(step_i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign addr_o = addr_q;

  // R4: a fixed side never moves on a beat
  a_r4_fixed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && hold_i && !load_i) |=> $stable(addr_o));

  // R5: reaching the pointer sends the side to the target
  a_r5_wrap_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !hold_i && wrap_i && at_ptr && !load_i) |=> (addr_o == $past(wrap_to_i)));

  // R3: without a beat or a load the address holds
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !load_i) |=> $stable(addr_o));

endmodule

// File: rtl/dma_seq_level.sv
module dma_seq_level #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [CNT_W-1:0] beat_i,
  input  logic             outer_last_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             cnt_en;
  logic             own_last;

  assign own_last = (cnt_q <= beat_i);
  assign last_o   = own_last | outer_last_i;
  assign cnt_en   = load_i | adv_i;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (adv_i) begin
      cnt_d = last_o ? reload_i : (cnt_q - beat_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R6: a beat inside a level always shrinks the remaining count
  a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !last_o && !load_i) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_addr_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STEP_W = 16,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [31:0]       cfg_word,
  input  logic [CNT_W-1:0]  blk_len,
  input  logic [CNT_W-1:0]  trsc_len,
  input  logic [ADDR_W-1:0] src_start,
  input  logic [ADDR_W-1:0] dst_start,
  input  logic [STEP_W-1:0] src_step,
  input  logic [STEP_W-1:0] dst_step,
  input  logic [ADDR_W-1:0] wrap_ptr,
  input  logic [ADDR_W-1:0] wrap_to,
  input  logic              req,
  input  logic              beat_ready,
  output logic              busy,
  output logic              beat_valid,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [3:0]        beat_bytes,
  output logic [3:0]        wr_bytes,
  output logic              frag_done,
  output logic              blk_done,
  output logic              trsc_done
);

  localparam int LV_FRAG = 0;
  localparam int LV_BLK  = 1;
  localparam int LV_TRSC = 2;

  seq_state_e        st_d, st_q;
  chan_cfg_t         cfg;
  logic [CNT_W-1:0]  r_blk, r_trsc;
  logic [STEP_W-1:0] r_sstep, r_dstep;
  logic [ADDR_W-1:0] r_wptr, r_wto;
  logic              load, adv;
  logic [CNT_W-1:0]  beat_cnt;

  logic [ADDR_W-1:0] side_init [NUM_SIDES];
  logic [STEP_W-1:0] side_step [NUM_SIDES];
  logic              side_hold [NUM_SIDES];
  logic              side_wrap [NUM_SIDES];
  logic [ADDR_W-1:0] side_addr [NUM_SIDES];

  logic [CNT_W-1:0]  lv_load   [NUM_LVLS];
  logic [CNT_W-1:0]  lv_reload [NUM_LVLS];
  logic              lv_outer  [NUM_LVLS];
  logic              lv_last   [NUM_LVLS];

  logic              fd_d, bd_d, td_d;
  logic              fd_q, bd_q, td_q;

  assign load = start && (st_q == ST_IDLE) && !abort;
  assign adv  = (st_q == ST_RUN) && beat_ready && !abort;

  dma_seq_cfg #(
    .ADDR_W(ADDR_W), .STEP_W(STEP_W), .CNT_W(CNT_W)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .cfg_word_i (cfg_word),
    .blk_len_i  (blk_len),
    .trsc_len_i (trsc_len),
    .src_step_i (src_step),
    .dst_step_i (dst_step),
    .wrap_ptr_i (wrap_ptr),
    .wrap_to_i  (wrap_to),
    .cfg_o      (cfg),
    .blk_len_o  (r_blk),
    .trsc_len_o (r_trsc),
    .src_step_o (r_sstep),
    .dst_step_o (r_dstep),
    .wrap_ptr_o (r_wptr),
    .wrap_to_o  (r_wto)
  );

  assign beat_cnt = CNT_W'(wid_bytes(cfg.rd_wid));

  // side 0 = source, side 1 = destination
  assign side_init[0] = src_start;
  assign side_init[1] = dst_start;
  assign side_step[0] = r_sstep;
  assign side_step[1] = r_dstep;
  assign side_hold[0] = cfg.fix_en && !cfg.fix_sel;
  assign side_hold[1] = cfg.fix_en &&  cfg.fix_sel;
  assign side_wrap[0] = cfg.wrap_en && !cfg.wrap_sel;
  assign side_wrap[1] = cfg.wrap_en &&  cfg.wrap_sel;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : gen_side
    dma_seq_side #(
      .ADDR_W(ADDR_W), .STEP_W(STEP_W)
    ) u_side (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .init_i     (side_init[s]),
      .adv_i      (adv),
      .step_i     (side_step[s]),
      .hold_i     (side_hold[s]),
      .wrap_i     (side_wrap[s]),
      .wrap_ptr_i (r_wptr),
      .wrap_to_i  (r_wto),
      .addr_o     (side_addr[s])
    );
  end

  assign lv_load[LV_FRAG]   = CNT_W'(cfg_word[FRAG_W-1:0]);
  assign lv_load[LV_BLK]    = blk_len;
  assign lv_load[LV_TRSC]   = trsc_len;
  assign lv_reload[LV_FRAG] = CNT_W'(cfg.frag_len);
  assign lv_reload[LV_BLK]  = r_blk;
  assign lv_reload[LV_TRSC] = r_trsc;

  for (genvar l = 0; l < NUM_LVLS; l++) begin : gen_lvl
    if (l == NUM_LVLS - 1) begin : g_top
      assign lv_outer[l] = 1'b0;
    end else begin : g_inner
      assign lv_outer[l] = lv_last[l+1];
    end
    dma_seq_level #(
      .CNT_W(CNT_W)
    ) u_lvl (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (load),
      .load_val_i   (lv_load[l]),
      .adv_i        (adv),
      .reload_i     (lv_reload[l]),
      .beat_i       (beat_cnt),
      .outer_last_i (lv_outer[l]),
      .last_o       (lv_last[l])
    );
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (load) st_d = ST_WAIT;
      ST_WAIT: if (req)  st_d = ST_RUN;
      ST_RUN: begin
        if (adv) begin
          if (lv_last[LV_TRSC]) begin
            st_d = ST_IDLE;
          end else if (cfg.mode == RQ_FRAG && lv_last[LV_FRAG]) begin
            st_d = ST_WAIT;
          end else if (cfg.mode == RQ_BLOCK && lv_last[LV_BLK]) begin
            st_d = ST_WAIT;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (abort) st_d = ST_IDLE;
  end

  always_comb begin
    fd_d = adv && lv_last[LV_FRAG];
    bd_d = adv && lv_last[LV_BLK];
    td_d = adv && lv_last[LV_TRSC];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      fd_q <= 1'b0;
      bd_q <= 1'b0;
      td_q <= 1'b0;
    end else begin
      st_q <= st_d;
      fd_q <= fd_d;
      bd_q <= bd_d;
      td_q <= td_d;
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign beat_valid = (st_q == ST_RUN);
  assign src_addr   = side_addr[0];
  assign dst_addr   = side_addr[1];
  assign beat_bytes = wid_bytes(cfg.rd_wid);
  assign wr_bytes   = wid_bytes(cfg.wr_wid);
  assign frag_done  = fd_q;
  assign blk_done   = bd_q;
  assign trsc_done  = td_q;

  // R6: outer level ends imply the inner ones
  a_r6_nested_done: assert property (@(posedge clk) disable iff (!rst_n)
    (trsc_done |-> blk_done) and (blk_done |-> frag_done));

  // R9: the transaction end leaves the block idle
  a_r9_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    trsc_done |-> (!busy && !beat_valid));

  // R1: busy only rises after a start pulse
  a_r1_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R11: abort always lands in idle
  a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !frag_done));

  // R7: fragment mode stops after an inner fragment end
  a_r7_frag_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cfg.mode == RQ_FRAG && lv_last[LV_FRAG] && !lv_last[LV_TRSC]) |=> (busy && !beat_valid));

  // R3: no accepted beat, no done pulse
  a_r3_no_beat_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> !frag_done);

endmodule

// File: tb/dma_addr_seq_tb_top.sv
module dma_addr_seq_tb_top;

  localparam int ADDR_W = 32;
  localparam int STEP_W = 16;
  localparam int CNT_W  = 24;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start, abort, req, beat_ready;
  logic [31:0]       cfg_word;
  logic [CNT_W-1:0]  blk_len, trsc_len;
  logic [ADDR_W-1:0] src_start, dst_start, wrap_ptr, wrap_to;
  logic [STEP_W-1:0] src_step, dst_step;
  logic              busy, beat_valid, frag_done, blk_done, trsc_done;
  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic [3:0]        beat_bytes, wr_bytes;

  int checks = 0;
  int errors = 0;

  int   c_sw, c_dw, c_mode, c_flen, c_blk, c_trsc;
  bit   c_wsel, c_wen, c_fsel, c_fen;
  logic [31:0] c_src, c_dst, c_wp, c_wt, c_ss, c_ds;

  always #2 clk = ~clk;

  dma_addr_seq #(.ADDR_W(ADDR_W), .STEP_W(STEP_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .cfg_word(cfg_word),
    .blk_len(blk_len), .trsc_len(trsc_len), .src_start(src_start), .dst_start(dst_start),
    .src_step(src_step), .dst_step(dst_step), .wrap_ptr(wrap_ptr), .wrap_to(wrap_to),
    .req(req), .beat_ready(beat_ready), .busy(busy), .beat_valid(beat_valid),
    .src_addr(src_addr), .dst_addr(dst_addr), .beat_bytes(beat_bytes), .wr_bytes(wr_bytes),
    .frag_done(frag_done), .blk_done(blk_done), .trsc_done(trsc_done)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic drive_cfg();
    cfg_word  = {c_sw[1:0], c_dw[1:0], 2'b00, c_mode[1:0], c_wsel, c_wen, c_fsel, c_fen,
                 3'b000, c_flen[16:0]};
    blk_len   = CNT_W'(c_blk);
    trsc_len  = CNT_W'(c_trsc);
    src_start = c_src;
    dst_start = c_dst;
    src_step  = c_ss[STEP_W-1:0];
    dst_step  = c_ds[STEP_W-1:0];
    wrap_ptr  = c_wp;
    wrap_to   = c_wt;
  endtask

  task automatic set_cfg(input int sw, input int mode, input int flen, input int blk, input int trsc,
                         input logic [31:0] src, input logic [31:0] ss,
                         input logic [31:0] dst, input logic [31:0] ds,
                         input bit fen, input bit fsel, input bit wen, input bit wsel,
                         input logic [31:0] wp, input logic [31:0] wt);
    c_sw = sw; c_dw = sw; c_mode = mode; c_flen = flen; c_blk = blk; c_trsc = trsc;
    c_src = src; c_ss = ss; c_dst = dst; c_ds = ds;
    c_fen = fen; c_fsel = fsel; c_wen = wen; c_wsel = wsel; c_wp = wp; c_wt = wt;
  endtask

  // shared engine: start, request, run beats against a byte-level model
  task automatic run_xfer(input string atag, input bit bp);
    logic [31:0] es, ed;
    int b, fc, bc, tc, cyc, guard;
    bit fin, rdy, lf, lb, lt;
    string rq;
    es = c_src; ed = c_dst; b = 1 << c_sw;
    fc = c_flen; bc = c_blk; tc = c_trsc; cyc = 0; guard = 0; fin = 0;
    drive_cfg();
    start = 1'b1;
    step();
    start = 1'b0;
    chk(busy == 1'b1, "R1", "busy after start", 64'(busy), 1);
    chk(beat_valid == 1'b0, "R1", "no beat before req", 64'(beat_valid), 0);
    chk(src_addr == es && dst_addr == ed, "R1", "start addresses", {src_addr, dst_addr}, {es, ed});
    chk(beat_bytes == 4'(b), "R2", "read beat size", 64'(beat_bytes), 64'(b));
    chk(wr_bytes == 4'(1 << c_dw), "R2", "write beat size", 64'(wr_bytes), 64'(1 << c_dw));
    req = 1'b1;
    step();
    req = 1'b0;
    while (!fin && guard < 1000) begin
      guard++;
      rdy = bp ? ((cyc % 3) != 2) : 1'b1;
      beat_ready = rdy;
      chk(beat_valid == 1'b1, "R3", "beat presented", 64'(beat_valid), 1);
      chk(src_addr == es, atag, "src addr", 64'(src_addr), 64'(es));
      chk(dst_addr == ed, atag, "dst addr", 64'(dst_addr), 64'(ed));
      step();
      cyc++;
      if (rdy) begin
        lt = (tc <= b);
        lb = lt || (bc <= b);
        lf = lb || (fc <= b);
        if (!(c_fen && !c_fsel)) begin
          if (c_wen && !c_wsel && es == c_wp) es = c_wt;
          else es = es + c_ss;
        end
        if (!(c_fen && c_fsel)) begin
          if (c_wen && c_wsel && ed == c_wp) ed = c_wt;
          else ed = ed + c_ds;
        end
        chk(frag_done == lf, "R6", "frag_done", 64'(frag_done), 64'(lf));
        chk(blk_done == lb, "R6", "blk_done", 64'(blk_done), 64'(lb));
        chk(trsc_done == lt, "R6", "trsc_done", 64'(trsc_done), 64'(lt));
        fc = lf ? c_flen : fc - b;
        bc = lb ? c_blk : bc - b;
        tc = lt ? c_trsc : tc - b;
        if (lt) begin
          beat_ready = 1'b0;
          chk(busy == 1'b0 && beat_valid == 1'b0, "R9", "idle at end",
              {busy, beat_valid}, 0);
          fin = 1;
        end else if ((c_mode == 0 && lf) || (c_mode == 1 && lb)) begin
          beat_ready = 1'b0;
          rq = (c_mode == 0) ? "R7" : "R8";
          chk(beat_valid == 1'b0, rq, "stall after unit", 64'(beat_valid), 0);
          step();
          chk(beat_valid == 1'b0 && busy == 1'b1, rq, "still waiting", {busy, beat_valid}, 2);
          chk(src_addr == es, rq, "address held in wait", 64'(src_addr), 64'(es));
          req = 1'b1;
          step();
          req = 1'b0;
        end
      end else begin
        chk({frag_done, blk_done, trsc_done} == 3'b000, "R3", "no done on stall",
            {frag_done, blk_done, trsc_done}, 0);
      end
    end
    beat_ready = 1'b0;
    chk(fin, "R9", "transaction finished", 64'(fin), 1);
    step();
  endtask

  task automatic t_reset();
    chk(busy == 1'b0 && beat_valid == 1'b0, "R1", "reset idle", {busy, beat_valid}, 0);
    chk({frag_done, blk_done, trsc_done} == 3'b000, "R1", "reset done flags",
        {frag_done, blk_done, trsc_done}, 0);
  endtask

  task automatic t_mem_to_dev();   // R4 destination fixed
    set_cfg(2, 2, 8, 32, 32, 32'h0000_1000, 4, 32'h0000_8000, 0, 1, 1, 0, 0, 0, 0);
    run_xfer("R4", 0);
  endtask

  task automatic t_dev_to_mem();   // R4 source fixed
    set_cfg(1, 2, 4, 8, 8, 32'h0000_7000, 0, 32'h0000_2000, 2, 1, 0, 0, 0, 0, 0);
    run_xfer("R4", 0);
  endtask

  task automatic t_wrap_src();     // R5 source ring
    set_cfg(2, 2, 64, 24, 24, 32'h0000_2000, 4, 32'h0000_3000, 4, 0, 0, 1, 0,
            32'h0000_2008, 32'h0000_2000);
    run_xfer("R5", 0);
  endtask

  task automatic t_wrap_dst();     // R5 destination ring, source fixed
    set_cfg(0, 2, 64, 7, 7, 32'h0000_6000, 0, 32'h0000_4000, 1, 1, 0, 1, 1,
            32'h0000_4002, 32'h0000_4000);
    run_xfer("R5", 0);
  endtask

  task automatic t_frag_mode();    // R7
    set_cfg(0, 0, 4, 12, 12, 32'h0000_0100, 1, 32'h0000_0900, 0, 1, 1, 0, 0, 0, 0);
    run_xfer("R7", 0);
  endtask

  task automatic t_block_mode();   // R8
    set_cfg(2, 1, 4, 8, 16, 32'h0000_0200, 4, 32'h0000_0A00, 4, 0, 0, 0, 0, 0, 0);
    run_xfer("R8", 0);
  endtask

  task automatic t_backpressure(); // R3 and R6 with uneven boundaries
    set_cfg(1, 2, 6, 10, 14, 32'h0000_0300, 2, 32'h0000_0B00, 2, 0, 0, 0, 0, 0, 0);
    run_xfer("R3", 1);
  endtask

  task automatic t_list_wide();    // R9 list mode, R2 eight-byte beats
    set_cfg(3, 3, 16, 32, 32, 32'h0000_4000, 8, 32'h0000_C000, 0, 1, 1, 0, 0, 0, 0);
    run_xfer("R9", 0);
  endtask

  task automatic t_restart_abort(); // R10, R11
    set_cfg(2, 2, 64, 64, 64, 32'h0000_1000, 4, 32'h0000_5000, 0, 1, 1, 0, 0, 0, 0);
    drive_cfg();
    start = 1'b1; step(); start = 1'b0;
    req = 1'b1; step(); req = 1'b0;
    beat_ready = 1'b1;
    step();
    beat_ready = 1'b0;
    chk(src_addr == 32'h1004, "R3", "first advance", 64'(src_addr), 64'h1004);
    src_start = 32'h0000_9000;
    src_step  = 16'd8;
    cfg_word  = 32'h0000_0040;
    start = 1'b1; step(); start = 1'b0;
    chk(src_addr == 32'h1004, "R10", "restart ignored addr", 64'(src_addr), 64'h1004);
    chk(busy && beat_valid, "R10", "restart ignored state", {busy, beat_valid}, 3);
    beat_ready = 1'b1; step(); beat_ready = 1'b0;
    chk(src_addr == 32'h1008, "R10", "old step kept", 64'(src_addr), 64'h1008);
    chk(beat_bytes == 4'd4, "R10", "old width kept", 64'(beat_bytes), 4);
    abort = 1'b1; beat_ready = 1'b1; step(); abort = 1'b0; beat_ready = 1'b0;
    chk(busy == 1'b0 && beat_valid == 1'b0, "R11", "abort idle", {busy, beat_valid}, 0);
    chk(src_addr == 32'h1008, "R11", "abort no advance", 64'(src_addr), 64'h1008);
    chk({frag_done, blk_done, trsc_done} == 3'b000, "R11", "abort no done",
        {frag_done, blk_done, trsc_done}, 0);
    abort = 1'b1; start = 1'b1; step(); abort = 1'b0; start = 1'b0;
    chk(busy == 1'b0, "R11", "abort beats start", 64'(busy), 0);
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; abort = 1'b0; req = 1'b0; beat_ready = 1'b0;
    cfg_word = '0; blk_len = '0; trsc_len = '0; src_start = '0; dst_start = '0;
    src_step = '0; dst_step = '0; wrap_ptr = '0; wrap_to = '0;
    repeat (3) step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_mem_to_dev();
    t_dev_to_mem();
    t_wrap_src();
    t_wrap_dst();
    t_frag_mode();
    t_block_mode();
    t_backpressure();
    t_list_wide();
    t_restart_abort();
    t_mem_to_dev();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule